// File: doc/BRIEF.md
# Power-Cap Mailbox Command Processor

This block serves a request/response mailbox that lives in a small byte-addressed shared memory. A software agent fills in a command record and raises its ready flag. On every pulse of the periodic `tick` input the block looks at the mailbox, and it handles at most one request per command. Each step of the work is a byte access on a synchronous single-port memory interface, and an internal sequencer issues one access per cycle.

The block handles one operation, which sets the power cap. It holds the current cap and a cap-type code, and it also presents fixed limit values and an activity state. A new request first gets an in-progress mark. The reply is written on a later tick. The block writes the whole reply record before it releases the mailbox. It then strobes `msg_pulse` for one cycle, toward the interrupt logic.

Top module: `mbx_pcap_proc`

## Requirements
- R1: After reset the outputs read as follows: cap_now = 100, cap_max = 100, cap_hard_min = 10, cap_soft_min = 20, run_state = 0x03, cap_kind = 0x00. msg_pulse is low.
- R2: On a tick the block does its work only when the command flag byte (command record offset 0) equals exactly 0x80. Any other value leaves the block with no memory write and no pulse.
- R3: Suppose a command is pending and the response flag byte (response record offset 0) reads 0x00. The block then writes 0x02 into that byte and does nothing more on that tick: there is no other write, no pulse and no cap change. A later tick handles the command.
- R4: Suppose a command is pending and the response flag is neither 0x00 nor 0x02. The reply then carries status 0x15 with a data length of 0, and the cap is left as it was.
- R5: The command record holds flag at offset 0, request ID at 1, opcode at 2, a spare byte at 3, a big-endian length at 4 and 5, and data at 6 and 7. The reply record holds the request ID at offset 1, the opcode at 2, the status at 3, a big-endian length at 4 and 5, and the payload at 6 and 7. The request ID and the opcode are echoed into it. The block writes all reply bytes first, then writes 0x01 to the response flag, and last writes 0x00 to the command flag.
- R6: `msg_pulse` goes high for exactly one cycle after each posted reply.
- R7: A request with opcode 0xD1 and a length other than 2 returns status 0x12. Its payload is the current cap, 2 bytes, and the cap is left as it was.
- R8: A request with opcode 0xD1, length 2 and value 0 clears the cap. cap_kind becomes 0x00 and cap_now becomes 100. The reply carries status 0x00 with payload 100.
- R9: A request with opcode 0xD1, length 2 and a nonzero value sets cap_kind to 0x02 and stores the value clamped to the range 10 to 100. The reply carries status 0x00 with the stored cap as payload.
- R10: Any other opcode returns status 0x11 with length 0. The payload bytes are not written.
- R11: A tick that arrives while the block is still busy with an earlier tick is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle poll pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| msg_pulse | output | 1 | One-cycle strobe after a posted reply |
| cap_now | output | 16 | Current power cap in watts |
| cap_kind | output | 8 | Cap type: 0x00 none, 0x02 set in-band |
| cap_max | output | 16 | Maximum cap in watts |
| cap_hard_min | output | 16 | Hard minimum cap in watts |
| cap_soft_min | output | 16 | Soft minimum cap in watts |
| run_state | output | 8 | Activity state, 0x03 = active |

## Verification
The assertions check, on every cycle, the following: the stored cap stays inside its hard limits, the cap type takes only its two legal codes, a cleared type always goes with the maximum cap, and the strobe is a single cycle that follows directly after the command flag is released. Other behaviour can be shown only by the bench's scenarios. This covers the status and payload chosen for each opcode, length and value, the clamping boundaries, the one-tick in-progress handshake, the rejection of flags other than 0x80, the ignored tick while busy, and the order of the reply writes.

// File: rtl/mbx_pkg.sv
// Package: shared codes and types of the power-cap mailbox processor.
// Assumes byte-wide shared memory and 16-bit big-endian cap values.
package mbx_pkg;
    localparam logic [7:0] FLAG_CMD_READY = 8'h80;
    localparam logic [7:0] FLAG_RSP_BUSY  = 8'h02;
    localparam logic [7:0] FLAG_RSP_DONE  = 8'h01;
    localparam logic [7:0] OP_SET_CAP     = 8'hD1;
    localparam logic [7:0] STS_OK         = 8'h00;
    localparam logic [7:0] STS_BAD_OP     = 8'h11;
    localparam logic [7:0] STS_BAD_LEN    = 8'h12;
    localparam logic [7:0] STS_INTERNAL   = 8'h15;
    localparam logic [7:0] KIND_NONE      = 8'h00;
    localparam logic [7:0] KIND_INBAND    = 8'h02;
    localparam logic [7:0] RUN_ACTIVE     = 8'h03;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RD_REQ, SQ_RD_GET, SQ_DECIDE, SQ_WR, SQ_PULSE
    } seq_state_t;

    typedef struct packed {
        logic [7:0]  status;
        logic        has_data;
        logic [15:0] payload;
    } reply_t;
endpackage

// File: rtl/mbx_cap_eval.sv
// Module: mbx_cap_eval
// Combinational command evaluator. From the captured request fields and the
// current cap it picks the reply status and payload, and any cap update.
// Assumes rsp_flag was already found nonzero by the sequencer.
module mbx_cap_eval
    import mbx_pkg::*;
#(
    parameter logic [15:0] CAP_MAX      = 16'd100,
    parameter logic [15:0] CAP_HARD_MIN = 16'd10
) (
    input  logic [7:0]  rsp_flag,
    input  logic [7:0]  opcode,
    input  logic [15:0] data_len,
    input  logic [15:0] req_val,
    input  logic [15:0] cur_cap,
    output reply_t      reply,
    output logic        cap_load,
    output logic [15:0] cap_next,
    output logic [7:0]  kind_next
);
    // Decode the request into a reply and an optional cap update.
    always_comb begin
        reply     = '0;
        cap_load  = 1'b0;
        cap_next  = cur_cap;
        kind_next = KIND_NONE;
        if (rsp_flag != FLAG_RSP_BUSY) begin
            reply.status = STS_INTERNAL;
        end else if (opcode == OP_SET_CAP) begin
            if (data_len != 16'd2) begin
                reply.status   = STS_BAD_LEN;
                reply.has_data = 1'b1;
                reply.payload  = cur_cap;
            end else begin
                cap_load = 1'b1;
                if (req_val == 16'd0) begin
                    kind_next = KIND_NONE;
                    cap_next  = CAP_MAX;
                end else begin
                    kind_next = KIND_INBAND;
                    if (req_val < CAP_HARD_MIN)
                        cap_next = CAP_HARD_MIN;
                    else if (req_val > CAP_MAX)
                        cap_next = CAP_MAX;
                    else
                        cap_next = req_val;
                end
                reply.status   = STS_OK;
                reply.has_data = 1'b1;
                reply.payload  = cap_next;
            end
        end else begin
            reply.status = STS_BAD_OP;
        end
    end
endmodule

// File: rtl/mbx_cap_regs.sv
// Module: mbx_cap_regs
// Holds the current cap, its type code, the fixed limits and the activity
// state. Assumes load is a single-cycle strobe from the sequencer.
module mbx_cap_regs
    import mbx_pkg::*;
#(
    parameter logic [15:0] CAP_MAX      = 16'd100,
    parameter logic [15:0] CAP_HARD_MIN = 16'd10,
    parameter logic [15:0] CAP_SOFT_MIN = 16'd20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] cap_in,
    input  logic [7:0]  kind_in,
    output logic [15:0] cap_now,
    output logic [7:0]  cap_kind,
    output logic [15:0] cap_max,
    output logic [15:0] cap_hard_min,
    output logic [15:0] cap_soft_min,
    output logic [7:0]  run_state
);
    // Cap and type registers: reset to the uncapped state and update on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_now  <= CAP_MAX;
            cap_kind <= KIND_NONE;
        end else if (load) begin
            cap_now  <= cap_in;
            cap_kind <= kind_in;
        end
    end

    // Limit and state registers: take their values at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_max      <= CAP_MAX;
            cap_hard_min <= CAP_HARD_MIN;
            cap_soft_min <= CAP_SOFT_MIN;
            run_state    <= RUN_ACTIVE;
        end
    end
endmodule

// File: rtl/mbx_seq.sv
// Module: mbx_seq
// Mailbox access sequencer. After an accepted tick it reads the request
// bytes one access at a time and asks the evaluator for a decision. It
// then writes the reply header and payload, then the response flag, then
// the command-flag release, and finally strobes msg_pulse. Assumes memory
// read data is valid one cycle after the read request. Ticks are ignored
// while the sequencer is busy.
module mbx_seq
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CMD_BASE = 0,
    parameter int RSP_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        rsp_flag,
    output logic [7:0]        opcode,
    output logic [15:0]       data_len,
    output logic [15:0]       req_val,
    input  reply_t            reply,
    output logic              decide_stb,
    output logic              msg_pulse
);
    localparam int          FIELDS     = 8;
    localparam logic [2:0]  RD_FLAG    = 3'd0;
    localparam logic [2:0]  RD_RSPFLAG = 3'd1;
    localparam logic [2:0]  RD_LAST    = 3'(FIELDS - 1);
    localparam logic [3:0]  WR_HDR_END = 4'd4;
    localparam logic [3:0]  WR_FLAG    = 4'd7;
    localparam logic [3:0]  WR_RELEASE = 4'd8;
    localparam logic [3:0]  WR_BUSY    = 4'd9;

    seq_state_t  state_q;
    logic [2:0]  rd_idx_q;
    logic [3:0]  wr_idx_q;
    logic [7:0]  fld_q [FIELDS];
    reply_t      reply_q;
    logic [7:0]  wr_byte;

    // Read address: flags first, then request ID, opcode, length and data.
    function automatic logic [ADDR_W-1:0] rd_addr(input logic [2:0] idx);
        case (idx)
            3'd1:    return ADDR_W'(RSP_BASE);
            3'd2:    return ADDR_W'(CMD_BASE + 1);
            3'd3:    return ADDR_W'(CMD_BASE + 2);
            default: return ADDR_W'(CMD_BASE + int'(idx));
        endcase
    endfunction

    // Write address: reply body bytes, then the response flag, then the command flag.
    function automatic logic [ADDR_W-1:0] wr_addr(input logic [3:0] idx);
        if (idx == WR_RELEASE)
            return ADDR_W'(CMD_BASE);
        else if (idx == WR_FLAG || idx == WR_BUSY)
            return ADDR_W'(RSP_BASE);
        else
            return ADDR_W'(RSP_BASE + 1 + int'(idx));
    endfunction

    // Sequencer state, captured request bytes and latched reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            rd_idx_q <= '0;
            wr_idx_q <= '0;
            reply_q  <= '0;
            for (int i = 0; i < FIELDS; i++) fld_q[i] <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (tick) begin
                        rd_idx_q <= RD_FLAG;
                        state_q  <= SQ_RD_REQ;
                    end
                end
                SQ_RD_REQ: state_q <= SQ_RD_GET;
                SQ_RD_GET: begin
                    fld_q[rd_idx_q] <= mem_rdata;
                    if (rd_idx_q == RD_FLAG && mem_rdata != FLAG_CMD_READY) begin
                        state_q <= SQ_IDLE;
                    end else if (rd_idx_q == RD_RSPFLAG && mem_rdata == 8'h00) begin
                        wr_idx_q <= WR_BUSY;
                        state_q  <= SQ_WR;
                    end else if (rd_idx_q == RD_LAST) begin
                        state_q <= SQ_DECIDE;
                    end else begin
                        rd_idx_q <= rd_idx_q + 3'd1;
                        state_q  <= SQ_RD_REQ;
                    end
                end
                SQ_DECIDE: begin
                    reply_q  <= reply;
                    wr_idx_q <= '0;
                    state_q  <= SQ_WR;
                end
                SQ_WR: begin
                    if (wr_idx_q == WR_BUSY)
                        state_q <= SQ_IDLE;
                    else if (wr_idx_q == WR_RELEASE)
                        state_q <= SQ_PULSE;
                    else if (wr_idx_q == WR_HDR_END && !reply_q.has_data)
                        wr_idx_q <= WR_FLAG;
                    else
                        wr_idx_q <= wr_idx_q + 4'd1;
                end
                SQ_PULSE: state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    // Byte written for the current write step.
    always_comb begin
        case (wr_idx_q)
            4'd0:    wr_byte = fld_q[2];
            4'd1:    wr_byte = fld_q[3];
            4'd2:    wr_byte = reply_q.status;
            4'd3:    wr_byte = 8'h00;
            4'd4:    wr_byte = reply_q.has_data ? 8'd2 : 8'd0;
            4'd5:    wr_byte = reply_q.payload[15:8];
            4'd6:    wr_byte = reply_q.payload[7:0];
            4'd7:    wr_byte = FLAG_RSP_DONE;
            4'd9:    wr_byte = FLAG_RSP_BUSY;
            default: wr_byte = 8'h00;
        endcase
    end

    // Memory port and handshake outputs.
    always_comb begin
        mem_en     = (state_q == SQ_RD_REQ) || (state_q == SQ_WR);
        mem_we     = (state_q == SQ_WR);
        mem_addr   = (state_q == SQ_WR) ? wr_addr(wr_idx_q) : rd_addr(rd_idx_q);
        mem_wdata  = (state_q == SQ_WR) ? wr_byte : 8'h00;
        decide_stb = (state_q == SQ_DECIDE);
        msg_pulse  = (state_q == SQ_PULSE);
    end

    assign rsp_flag = fld_q[1];
    assign opcode   = fld_q[3];
    assign data_len = {fld_q[4], fld_q[5]};
    assign req_val  = {fld_q[6], fld_q[7]};
endmodule

// File: rtl/mbx_pcap_proc.sv
// Module: mbx_pcap_proc (top)
// Power-cap mailbox command processor. It ties the access sequencer, the
// command evaluator and the cap registers together. Assumes tick is a
// single-cycle pulse and that the shared memory is a synchronous byte port.
module mbx_pcap_proc
    import mbx_pkg::*;
#(
    parameter int          ADDR_W       = 8,
    parameter int          CMD_BASE     = 0,
    parameter int          RSP_BASE     = 16,
    parameter logic [15:0] CAP_MAX      = 16'd100,
    parameter logic [15:0] CAP_HARD_MIN = 16'd10,
    parameter logic [15:0] CAP_SOFT_MIN = 16'd20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              msg_pulse,
    output logic [15:0]       cap_now,
    output logic [7:0]        cap_kind,
    output logic [15:0]       cap_max,
    output logic [15:0]       cap_hard_min,
    output logic [15:0]       cap_soft_min,
    output logic [7:0]        run_state
);
    logic [7:0]  rsp_flag, opcode, kind_next;
    logic [15:0] data_len, req_val, cap_next;
    logic        decide_stb, cap_load;
    reply_t      reply;

    mbx_seq #(.ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .RSP_BASE(RSP_BASE)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_flag(rsp_flag), .opcode(opcode), .data_len(data_len), .req_val(req_val),
        .reply(reply), .decide_stb(decide_stb), .msg_pulse(msg_pulse)
    );

    mbx_cap_eval #(.CAP_MAX(CAP_MAX), .CAP_HARD_MIN(CAP_HARD_MIN)) u_eval (
        .rsp_flag(rsp_flag), .opcode(opcode), .data_len(data_len), .req_val(req_val),
        .cur_cap(cap_now), .reply(reply), .cap_load(cap_load),
        .cap_next(cap_next), .kind_next(kind_next)
    );

    mbx_cap_regs #(.CAP_MAX(CAP_MAX), .CAP_HARD_MIN(CAP_HARD_MIN),
                   .CAP_SOFT_MIN(CAP_SOFT_MIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(cap_load && decide_stb),
        .cap_in(cap_next), .kind_in(kind_next),
        .cap_now(cap_now), .cap_kind(cap_kind), .cap_max(cap_max),
        .cap_hard_min(cap_hard_min), .cap_soft_min(cap_soft_min), .run_state(run_state)
    );
endmodule

// File: rtl/mbx_pcap_proc_chk.sv
// Module: mbx_pcap_proc_chk
// Assertion checker bound to mbx_pcap_proc. It watches only the top ports.
module mbx_pcap_proc_chk #(
    parameter int          ADDR_W       = 8,
    parameter int          CMD_BASE     = 0,
    parameter logic [15:0] CAP_MAX      = 16'd100,
    parameter logic [15:0] CAP_HARD_MIN = 16'd10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              msg_pulse,
    input logic [15:0]       cap_now,
    input logic [7:0]        cap_kind
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |=> !msg_pulse); // R6

    AST_PULSE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> $past(mem_en && mem_we && mem_addr == ADDR_W'(CMD_BASE)
                            && mem_wdata == 8'h00)); // R5

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_now >= CAP_HARD_MIN && cap_now <= CAP_MAX); // R9

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cap_kind == 8'h00 || cap_kind == 8'h02); // R9

    AST_CLEAR_MEANS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        cap_kind == 8'h00 |-> cap_now == CAP_MAX); // R8
endmodule

bind mbx_pcap_proc mbx_pcap_proc_chk #(
    .ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE), .CAP_MAX(CAP_MAX), .CAP_HARD_MIN(CAP_HARD_MIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .msg_pulse(msg_pulse),
    .cap_now(cap_now), .cap_kind(cap_kind)
);

// File: tb/mbx_pcap_proc_test.sv
module mbx_pcap_proc_test;
    localparam int CB = 0;
    localparam int RB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        mem_en, mem_we, msg_pulse;
    logic [7:0]  mem_addr, mem_wdata, cap_kind, run_state;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] cap_now, cap_max, cap_hard_min, cap_soft_min;

    logic        poke_en = 1'b0;
    logic [7:0]  poke_addr = 8'h00;
    logic [7:0]  poke_data = 8'h00;
    logic [7:0]  mem [256];
    int wseq = 0, pulse_cnt = 0, hdr_at = 0, rsp_at = 0, clr_at = 0;
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    mbx_pcap_proc uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .msg_pulse(msg_pulse),
        .cap_now(cap_now), .cap_kind(cap_kind), .cap_max(cap_max),
        .cap_hard_min(cap_hard_min), .cap_soft_min(cap_soft_min), .run_state(run_state)
    );

    // Shared memory model with write-order log and pulse counter
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wseq <= wseq + 1;
                if (mem_addr == 8'(RB) && mem_wdata == 8'h01) rsp_at <= wseq + 1;
                if (mem_addr == 8'(CB)) clr_at <= wseq + 1;
                if (mem_addr > 8'(RB) && mem_addr <= 8'(RB + 7)) hdr_at <= wseq + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
            end
        end
        if (msg_pulse) pulse_cnt <= pulse_cnt + 1;
    end

    // fields: op, len, val, status, rlen, payload, cap, kind
    localparam logic [103:0] VEC [12] = '{
        {8'hD1, 16'd2, 16'd50,     8'h00, 16'd2, 16'd50,  16'd50,  8'h02},
        {8'hD1, 16'd2, 16'd5,      8'h00, 16'd2, 16'd10,  16'd10,  8'h02},
        {8'hD1, 16'd2, 16'd10,     8'h00, 16'd2, 16'd10,  16'd10,  8'h02},
        {8'hD1, 16'd2, 16'd100,    8'h00, 16'd2, 16'd100, 16'd100, 8'h02},
        {8'hD1, 16'd2, 16'd101,    8'h00, 16'd2, 16'd100, 16'd100, 8'h02},
        {8'hD1, 16'd2, 16'hFFFF,   8'h00, 16'd2, 16'd100, 16'd100, 8'h02},
        {8'hD1, 16'd2, 16'd75,     8'h00, 16'd2, 16'd75,  16'd75,  8'h02},
        {8'hD1, 16'd3, 16'd20,     8'h12, 16'd2, 16'd75,  16'd75,  8'h02},
        {8'hD1, 16'h0102, 16'd30,  8'h12, 16'd2, 16'd75,  16'd75,  8'h02},
        {8'hD1, 16'd2, 16'd0,      8'h00, 16'd2, 16'd100, 16'd100, 8'h00},
        {8'h42, 16'd0, 16'd0,      8'h11, 16'd0, 16'd0,   16'd100, 8'h00},
        {8'hD0, 16'd2, 16'd60,     8'h11, 16'd0, 16'd0,   16'd100, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = 8'(a); poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic setup(input logic [7:0] cflag, input logic [7:0] rid,
                         input logic [7:0] op, input logic [15:0] len,
                         input logic [15:0] val, input logic [7:0] rflag);
        poke(CB + 0, cflag); poke(CB + 1, rid); poke(CB + 2, op); poke(CB + 3, 8'h00);
        poke(CB + 4, len[15:8]); poke(CB + 5, len[7:0]);
        poke(CB + 6, val[15:8]); poke(CB + 7, val[7:0]);
        poke(RB + 0, rflag);
        for (int k = 1; k < 8; k++) poke(RB + k, 8'hEE);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic fire();
        pulse_tick();
        repeat (60) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        int w0, p0;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cap_now", int'(cap_now), 100);
        chk("R1 cap_max", int'(cap_max), 100);
        chk("R1 hard_min", int'(cap_hard_min), 10);
        chk("R1 soft_min", int'(cap_soft_min), 20);
        chk("R1 run_state", int'(run_state), 3);
        chk("R1 cap_kind", int'(cap_kind), 0);
        chk("R1 msg_pulse", int'(msg_pulse), 0);

        // Vector table: request with response flag already in progress
        for (int i = 0; i < 12; i++) begin
            logic [103:0] v;
            v = VEC[i];
            setup(8'h80, 8'(8'h30 + i), v[103:96], v[95:80], v[79:64], 8'h02);
            w0 = wseq; p0 = pulse_cnt;
            fire();
            if (v[63:56] == 8'h12) tag = "R7";
            else if (v[63:56] == 8'h11) tag = "R10";
            else if (v[79:64] == 16'd0) tag = "R8";
            else tag = "R9";
            chk({tag, " status"}, int'(mem[RB + 3]), int'(v[63:56]));
            chk({tag, " length"}, int'({mem[RB + 4], mem[RB + 5]}), int'(v[55:40]));
            if (v[55:40] == 16'd2)
                chk({tag, " payload"}, int'({mem[RB + 6], mem[RB + 7]}), int'(v[39:24]));
            else
                chk("R10 payload untouched", int'(mem[RB + 6]), 8'hEE);
            chk({tag, " cap_now"}, int'(cap_now), int'(v[23:8]));
            chk({tag, " cap_kind"}, int'(cap_kind), int'(v[7:0]));
            chk("R5 request id echo", int'(mem[RB + 1]), 8'h30 + i);
            chk("R5 opcode echo", int'(mem[RB + 2]), int'(v[103:96]));
            chk("R5 response flag", int'(mem[RB + 0]), 8'h01);
            chk("R5 command flag cleared", int'(mem[CB + 0]), 8'h00);
            chk("R5 write order", (hdr_at > w0 && hdr_at < rsp_at && rsp_at < clr_at) ? 1 : 0, 1);
            chk("R6 one pulse", pulse_cnt - p0, 1);
        end

        // R2: flag values other than 0x80 are ignored
        setup(8'h81, 8'h01, 8'hD1, 16'd2, 16'd40, 8'h02);
        w0 = wseq; p0 = pulse_cnt;
        fire();
        chk("R2 no writes 0x81", wseq - w0, 0);
        chk("R2 no pulse 0x81", pulse_cnt - p0, 0);
        chk("R2 cap kept 0x81", int'(cap_now), 100);
        setup(8'h00, 8'h01, 8'hD1, 16'd2, 16'd40, 8'h02);
        w0 = wseq;
        fire();
        chk("R2 no writes 0x00", wseq - w0, 0);
        setup(8'hC0, 8'h01, 8'hD1, 16'd2, 16'd40, 8'h02);
        w0 = wseq;
        fire();
        chk("R2 no writes 0xC0", wseq - w0, 0);
        chk("R2 response flag kept", int'(mem[RB + 0]), 8'h02);

        // R3: first tick only marks in progress, second replies
        setup(8'h80, 8'h55, 8'hD1, 16'd2, 16'd33, 8'h00);
        w0 = wseq; p0 = pulse_cnt;
        fire();
        chk("R3 flag in progress", int'(mem[RB + 0]), 8'h02);
        chk("R3 single write", wseq - w0, 1);
        chk("R3 no pulse", pulse_cnt - p0, 0);
        chk("R3 command still pending", int'(mem[CB + 0]), 8'h80);
        chk("R3 cap unchanged", int'(cap_now), 100);
        fire();
        chk("R3 second tick status", int'(mem[RB + 3]), 8'h00);
        chk("R3 second tick cap", int'(cap_now), 33);
        chk("R3 second tick pulse", pulse_cnt - p0, 1);
        chk("R3 second tick flag", int'(mem[RB + 0]), 8'h01);

        // R4: unexpected response flag gives internal error
        setup(8'h80, 8'h66, 8'hD1, 16'd2, 16'd40, 8'h05);
        p0 = pulse_cnt;
        fire();
        chk("R4 status", int'(mem[RB + 3]), 8'h15);
        chk("R4 length", int'({mem[RB + 4], mem[RB + 5]}), 0);
        chk("R4 cap unchanged", int'(cap_now), 33);
        chk("R4 request id echo", int'(mem[RB + 1]), 8'h66);
        chk("R4 pulse", pulse_cnt - p0, 1);

        // R11: tick during busy sequence is ignored
        setup(8'h80, 8'h77, 8'hD1, 16'd2, 16'd44, 8'h00);
        w0 = wseq; p0 = pulse_cnt;
        pulse_tick();
        pulse_tick();
        repeat (60) @(negedge clk);
        chk("R11 only in-progress write", wseq - w0, 1);
        chk("R11 no pulse", pulse_cnt - p0, 0);
        chk("R11 cap unchanged", int'(cap_now), 33);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule